// File: doc/BRIEF.md
# Serial Status Word Readout Port

This block is the slave side of a four-wire serial port on a receiver front end. The host selects the port by pulling chip select low. It then clocks command bits in on the data input with the serial clock, using the low idle level of mode 0. The block decides what kind of transfer is running from the very first bit it samples. A leading zero makes the transfer a status read. From the next falling clock edge the block drives the status word onto the data output, one bit per clock, while the host is still shifting the rest of its command word in. A leading one marks a control transfer. That transfer belongs to a separate command path, so the block only flags it and keeps its data output quiet.

The first eight positions of the status word hold eight status bits. Three of them are event flags: FIFO overflow, wake-up timer expiry and low supply. Each event flag is held in a flop that is set by a single-cycle pulse and cleared once the flag has been shifted out. The other five bits are passed through live from their sources: FIFO fill level reached, FIFO empty, and three signal-strength comparator outputs. The remaining frame positions are driven as zeros. The serial pins are brought into the system clock domain by synchroniser chains, and clock edges are detected in that domain.

Top module: `srd_status_port`

## Requirements
- R1: When the first SDI bit sampled after chip select falls is 0, the transfer is a status read. Frame bit 0 appears on SDO after the first falling SCK edge, and frame bit k appears after falling edge k+1.
- R2: When the first SDI bit is 1, the transfer is a control transfer. `ctl_xfer` is 1 until chip select rises, and SDO stays 0 for the whole transfer.
- R3: Frame positions 0 to 7 carry `stat_src[0]` to `stat_src[7]`, in this order: fill level reached, overflow, wake-up, low supply, FIFO empty, strength high, strength mid, strength low.
- R4: Frame positions 8 to FRAME_BITS-1 are 0. Every falling edge after the frame has ended also drives SDO to 0.
- R5: The positions set in LATCH_MASK (default positions 1, 2 and 3) are latched. A one-cycle high pulse on the source sets the flag, and the flag then reads 1 in the next status read.
- R6: A latched flag clears in the cycle its bit is shifted out, so a second read returns 0 for that bit.
- R7: An event pulse that arrives during a read, after its bit has been shifted out, leaves the flag set for the following read. A pulse in the same cycle as the clear also keeps the flag set.
- R8: A live position reports the value of its source at the falling edge that shifts it out, including a change made partway through the frame.
- R9: While synchronised chip select is high, SDO is 0 and the frame position returns to the start. A read that is cut short clears only the latched flags that were already shifted out.
- R10: SDO changes only on a synchronised falling SCK edge or when chip select is deselected. SDI is sampled on synchronised rising edges. Each input pin passes through SYNC_STAGES flops first.
- R11: After reset, SDO and `ctl_xfer` are 0 and all latched flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_sdi | input | 1 | Serial command data from the host |
| stat_src | input | 8 | Status sources: event pulses at the latched positions, levels at the others |
| spi_sdo | output | 1 | Serial status data to the host |
| ctl_xfer | output | 1 | High while the current transfer is a control transfer |

## Verification
The assertions assume that the serial pins are slow compared with the system clock. Each SCK level must last longer than the synchroniser delay, so the synchronised clock never produces a rising and a falling edge too close together. They also assume that an event source at a latched position is only ever a single-cycle pulse. The stimulus holds each SCK phase for four system clocks, changes SDI only together with a rising SCK, and drives the event inputs as one-cycle pulses from the falling system-clock edge. The live inputs are changed only while no bit is being shifted. A behavioural model in the bench follows the synchroniser delay, so every cycle can be compared exactly.

// File: rtl/srd_pkg.sv
package srd_pkg;
   localparam int STAT_BITS = 8;
   localparam int STAT_IW   = $clog2(STAT_BITS);

   // frame positions; the host decodes this order
   localparam int POS_FILL  = 0;
   localparam int POS_OVF   = 1;
   localparam int POS_WAKE  = 2;
   localparam int POS_LBAT  = 3;
   localparam int POS_EMPTY = 4;
   localparam int POS_SIG_H = 5;
   localparam int POS_SIG_M = 6;
   localparam int POS_SIG_L = 7;

   typedef enum logic [1:0] {
      XFER_IDLE = 2'd0,
      XFER_READ = 2'd1,
      XFER_CTRL = 2'd2
   } xfer_e;
endpackage

// File: rtl/srd_sync.sv
module srd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/srd_flags.sv
module srd_flags
   import srd_pkg::*;
#(
   parameter logic [STAT_BITS-1:0] LATCH_MASK = 8'b0000_1110
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_BITS-1:0] stat_src,
   input  logic [STAT_BITS-1:0] clr_pos,
   output logic [STAT_BITS-1:0] frame_bits
);
   for (genvar i = 0; i < STAT_BITS; i++) begin : g_pos
      if (LATCH_MASK[i]) begin : g_held
         logic flag_q;
         // a new event wins over the clear of the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~clr_pos[i]) | stat_src[i];
         end
         assign frame_bits[i] = flag_q;
      end else begin : g_live
         assign frame_bits[i] = stat_src[i];
      end
   end
endmodule

// File: rtl/srd_frame.sv
module srd_frame
   import srd_pkg::*;
#(
   parameter  int FRAME_BITS = 16,
   localparam int OCW        = $clog2(FRAME_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 csn_s,
   input  logic                 sck_s,
   input  logic                 sdi_s,
   input  logic [STAT_BITS-1:0] frame_bits,
   output logic                 sdo,
   output logic                 ctl_xfer,
   output logic                 fall_evt,
   output logic [OCW-1:0]       bit_idx,
   output logic [STAT_BITS-1:0] clr_pos
);
   logic  sck_q;
   logic  rise_evt;
   logic  shift_now;
   logic  next_bit;
   xfer_e mode_q;

   assign rise_evt  = sck_s & ~sck_q;
   assign fall_evt  = ~sck_s & sck_q;
   assign shift_now = fall_evt & ~csn_s & (mode_q == XFER_READ);
   assign next_bit  = (bit_idx < OCW'(STAT_BITS)) ? frame_bits[bit_idx[STAT_IW-1:0]] : 1'b0;
   assign ctl_xfer  = (mode_q == XFER_CTRL);

   always_comb begin
      for (int i = 0; i < STAT_BITS; i++)
         clr_pos[i] = shift_now && (bit_idx == OCW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         mode_q  <= XFER_IDLE;
         bit_idx <= '0;
         sdo     <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (csn_s) begin
            mode_q  <= XFER_IDLE;
            bit_idx <= '0;
            sdo     <= 1'b0;
         end else begin
            // the opcode is decided by the first sampled bit alone
            if (rise_evt && mode_q == XFER_IDLE)
               mode_q <= sdi_s ? XFER_CTRL : XFER_READ;
            if (shift_now) begin
               sdo <= next_bit;
               if (bit_idx != OCW'(FRAME_BITS)) bit_idx <= bit_idx + 1'b1;
            end else if (fall_evt) begin
               sdo <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/srd_status_port.sv
module srd_status_port
   import srd_pkg::*;
#(
   parameter  int                   SYNC_STAGES = 2,
   parameter  int                   FRAME_BITS  = 16,
   parameter  logic [STAT_BITS-1:0] LATCH_MASK  = 8'b0000_1110,
   localparam int                   OCW         = $clog2(FRAME_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_csn,
   input  logic                 spi_sck,
   input  logic                 spi_sdi,
   input  logic [STAT_BITS-1:0] stat_src,
   output logic                 spi_sdo,
   output logic                 ctl_xfer
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("srd_status_port: SYNC_STAGES must be at least 2");
   end
   if (FRAME_BITS < STAT_BITS) begin : g_bad_frame
      $error("srd_status_port: FRAME_BITS must cover the status bits");
   end

   logic                 csn_s, sck_s, sdi_s;
   logic                 fall_evt;
   logic [OCW-1:0]       bit_idx;
   logic [STAT_BITS-1:0] frame_bits;
   logic [STAT_BITS-1:0] clr_pos;

   srd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
      .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
   srd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
   srd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(spi_sdi), .q(sdi_s));

   srd_flags #(.LATCH_MASK(LATCH_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .stat_src(stat_src),
      .clr_pos(clr_pos), .frame_bits(frame_bits));

   srd_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sck_s(sck_s), .sdi_s(sdi_s),
      .frame_bits(frame_bits), .sdo(spi_sdo), .ctl_xfer(ctl_xfer),
      .fall_evt(fall_evt), .bit_idx(bit_idx), .clr_pos(clr_pos));
endmodule

// File: rtl/srd_status_chk.sv
module srd_status_chk
   import srd_pkg::*;
#(
   parameter  int                   FRAME_BITS = 16,
   parameter  logic [STAT_BITS-1:0] LATCH_MASK = 8'b0000_1110,
   localparam int                   OCW        = $clog2(FRAME_BITS + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 csn_s,
   input logic                 fall_evt,
   input logic [OCW-1:0]       bit_idx,
   input logic [STAT_BITS-1:0] stat_src,
   input logic [STAT_BITS-1:0] frame_bits,
   input logic [STAT_BITS-1:0] clr_pos,
   input logic                 spi_sdo,
   input logic                 ctl_xfer
);
   p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !spi_sdo);

   p_ctrl_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_xfer |-> !spi_sdo);

   p_sdo_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_sdo) |-> ($past(fall_evt) || $past(csn_s)));

   p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && bit_idx >= OCW'(STAT_BITS)) |=> !spi_sdo);

   p_single_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_pos));

   for (genvar i = 0; i < STAT_BITS; i++) begin : g_held_chk
      if (LATCH_MASK[i]) begin : g_on
         p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            stat_src[i] |=> frame_bits[i]);
         p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pos[i] && !stat_src[i]) |=> !frame_bits[i]);
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_bits[i] && !clr_pos[i]) |=> frame_bits[i]);
      end
   end
endmodule

bind srd_status_port srd_status_chk #(.FRAME_BITS(FRAME_BITS), .LATCH_MASK(LATCH_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .fall_evt(fall_evt), .bit_idx(bit_idx),
   .stat_src(stat_src), .frame_bits(frame_bits), .clr_pos(clr_pos),
   .spi_sdo(spi_sdo), .ctl_xfer(ctl_xfer));

// File: tb/tb_srd_status_port.sv
module tb_srd_status_port;
   localparam int CLK_PERIOD = 10;
   localparam int SY         = 2;
   localparam int FRAME      = 16;
   localparam int HALF       = 4;
   localparam logic [7:0] LM = 8'b0000_1110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csn = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic [7:0] stat = 8'h00;
   logic       sdo, ctl;
   int         n_chk = 0, n_fail = 0;
   logic [31:0] got;
   logic        ctl_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   srd_status_port #(.SYNC_STAGES(SY), .FRAME_BITS(FRAME), .LATCH_MASK(LM)) dut (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_sdi(sdi),
      .stat_src(stat), .spi_sdo(sdo), .ctl_xfer(ctl));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference: delayed pin histories, flag set, frame position
   bit p_sck[SY], p_sdi[SY], p_csn[SY];
   bit m_prev, m_sdo;
   int m_mode, m_pos;
   bit m_flag[8];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SY; i++) begin p_sck[i] = 0; p_sdi[i] = 0; p_csn[i] = 1; end
         m_prev = 0; m_sdo = 0; m_mode = 0; m_pos = 0;
         for (int i = 0; i < 8; i++) m_flag[i] = 0;
      end else begin
         bit s_sck, s_sdi, s_csn, rise, fall, val;
         bit nf[8];
         s_sck = p_sck[SY-1]; s_sdi = p_sdi[SY-1]; s_csn = p_csn[SY-1];
         rise = s_sck && !m_prev;
         fall = !s_sck && m_prev;
         val = 0;
         if (m_pos < 8) val = LM[m_pos] ? m_flag[m_pos] : stat[m_pos];
         for (int i = 0; i < 8; i++) begin
            bit gone;
            gone = !s_csn && fall && m_mode == 1 && m_pos == i;
            nf[i] = LM[i] ? ((m_flag[i] && !gone) || stat[i]) : 0;
         end
         if (s_csn) begin
            m_mode = 0; m_pos = 0; m_sdo = 0;
         end else begin
            if (rise && m_mode == 0) m_mode = s_sdi ? 2 : 1;
            if (fall) begin
               if (m_mode == 1) begin
                  m_sdo = val;
                  if (m_pos < FRAME) m_pos++;
               end else m_sdo = 0;
            end
         end
         for (int i = 0; i < 8; i++) m_flag[i] = nf[i];
         m_prev = s_sck;
         for (int i = SY-1; i > 0; i--) begin
            p_sck[i] = p_sck[i-1]; p_sdi[i] = p_sdi[i-1]; p_csn[i] = p_csn[i-1];
         end
         p_sck[0] = sck; p_sdi[0] = sdi; p_csn[0] = csn;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R10 sdo vs model", {31'd0, sdo}, {31'd0, m_sdo});
         check("R2 ctl_xfer vs model", {31'd0, ctl}, {31'd0, bit'(m_mode == 2)});
      end
   end

   task automatic xfer(input logic first, input int nbits);
      got = '0;
      ctl_seen = 1'b0;
      @(negedge clk) csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = (i == 0) ? first : 1'b0;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
         repeat (HALF) @(negedge clk);
         got[i] = sdo;
         if (ctl) ctl_seen = 1'b1;
      end
      csn = 1'b1;
      sdi = 1'b0;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic pulse(input int pos);
      @(negedge clk) stat[pos] = 1'b1;
      @(negedge clk) stat[pos] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 sdo after reset", {31'd0, sdo}, 32'd0);
      check("R11 ctl after reset", {31'd0, ctl}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // live: fill=1, empty=0, strength high=1, mid=0, low=1
      stat = 8'b1010_0001;
      xfer(1'b0, FRAME);
      check("R1 R3 status bits", {24'd0, got[7:0]}, 32'hA1);
      check("R11 latched clear after reset", {29'd0, got[3:1]}, 32'd0);
      check("R4 tail zero", {16'd0, got[15:8]}, 32'd0);

      pulse(1); pulse(3);
      repeat (4) @(negedge clk);
      xfer(1'b0, FRAME);
      check("R5 latched overflow/low supply", {24'd0, got[7:0]}, 32'hAB);
      xfer(1'b0, FRAME);
      check("R6 cleared by read", {24'd0, got[7:0]}, 32'hA1);

      pulse(2);
      xfer(1'b1, FRAME);
      check("R2 control sdo silent", got, 32'd0);
      check("R2 control flagged", {31'd0, ctl_seen}, 32'd1);
      check("R2 ctl dropped after deselect", {31'd0, ctl}, 32'd0);
      xfer(1'b0, FRAME);
      check("R2 flag kept across control", {24'd0, got[7:0]}, 32'hA5);

      fork
         xfer(1'b0, FRAME);
         begin repeat (40) @(negedge clk); stat[7] = 1'b0; end
      join
      check("R8 live change mid-frame", {24'd0, got[7:0]}, 32'h21);

      fork
         xfer(1'b0, FRAME);
         begin repeat (40) @(negedge clk); stat[2] = 1'b1; @(negedge clk) stat[2] = 1'b0; end
      join
      check("R7 event after its bit", {24'd0, got[7:0]}, 32'h21);
      xfer(1'b0, FRAME);
      check("R7 event kept for next read", {24'd0, got[7:0]}, 32'h25);

      pulse(1); pulse(2); pulse(3);
      xfer(1'b0, 3);
      check("R9 short read bits", {29'd0, got[2:0]}, 32'd7);
      check("R9 sdo low after deselect", {31'd0, sdo}, 32'd0);
      xfer(1'b0, FRAME);
      check("R9 only shifted flags cleared", {24'd0, got[7:0]}, 32'h29);

      xfer(1'b0, 20);
      check("R4 beyond frame zero", {12'd0, got[19:0]}, 32'h21);

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule